// File: doc/BRIEF.md
# Pipeline Trap Commit Controller

This block tracks faults and interrupts for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Next to the decode, execute and memory stage registers it keeps a valid bit, the instruction PC and one pending fault with its cause code. A fault found in any stage is attached to the instruction and moves with it. Nothing acts on it until that instruction reaches the memory stage, which is the commit point. There the block decides whether to trap, return from a handler, or let the instruction retire.

When a trap is taken, the block flushes every stage, blocks writeback of the committing instruction and points fetch at a fixed handler address. It also records the cause and the instruction PC, masks interrupts and enters kernel mode. A return-from-handler instruction at commit unmasks interrupts, leaves kernel mode and sends fetch back to the saved PC. The fault detectors and the handler code are not part of this block.

Top module: `trap_commit_unit`

## Requirements
- R1: After reset no kill, suppress or redirect output is high, the cause register and saved PC are 0, interrupts are masked (irqEnable 0) and kernelMode is 1.
- R2: A fault raised on an instruction in fetch, decode or execute does not take effect in that stage. It takes effect only in the cycle that instruction occupies the memory stage, three advancing cycles after it was fetched.
- R3: For one instruction, the fault from the earliest stage sets the cause. The codes are fetch address fault 1, illegal opcode 2, arithmetic overflow 3 and data address fault 4.
- R4: If extIrq is high, interrupts are enabled and the commit slot is valid, an interrupt is taken with cause 0. It wins over any synchronous fault on the same instruction.
- R5: In a trap cycle, killFetch, killDecode, killExecute, suppressWb and redirectValid are high and redirectPc equals HANDLER_PC (0x80 by default). From the next cycle the cause register holds the cause and the saved PC holds the committing instruction's PC.
- R6: Taking a trap clears irqEnable and sets kernelMode.
- R7: retExc with a valid commit slot and no trap sets irqEnable and clears kernelMode. In that cycle the fetch, decode and execute kills and redirectValid are high, redirectPc equals the saved PC, and suppressWb stays low.
- R8: No interrupt is taken while irqEnable is 0 or while the commit slot holds a bubble.
- R9: Flushed stages become bubbles with no pending fault. A bubble in the memory stage never traps, even with memAddrFault or extIrq high.
- R10: While stall is high, the decode slot keeps its PC and pending fault, and a bubble enters execute. The fault reaches commit one cycle later for each stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch stage holds a real instruction |
| fetchPc | input | PC_W | PC of the fetched instruction |
| fetchFault | input | 1 | Fetch address fault on the fetched instruction |
| decIllegal | input | 1 | Illegal opcode found in decode |
| exeOverflow | input | 1 | Overflow found in execute |
| memAddrFault | input | 1 | Data address fault found in the memory stage |
| extIrq | input | 1 | External interrupt request |
| retExc | input | 1 | Instruction in the memory stage is a return-from-handler |
| stall | input | 1 | Decode interlock: hold fetch and decode |
| killFetch | output | 1 | Discard the instruction in fetch |
| killDecode | output | 1 | Discard the instruction in decode |
| killExecute | output | 1 | Discard the instruction in execute |
| suppressWb | output | 1 | Block writeback of the committing instruction |
| redirectValid | output | 1 | Load redirectPc into the fetch PC |
| redirectPc | output | PC_W | Handler address or saved PC |
| causeReg | output | 3 | Cause of the last trap |
| epcReg | output | PC_W | PC of the last trapped instruction |
| irqEnable | output | 1 | Interrupts unmasked |
| kernelMode | output | 1 | Privileged mode |

## Verification
A cycle table drives instructions that carry faults from several stages at once. This shows whether the earliest-stage cause is kept or a later one overwrites it. The same table raises an interrupt together with a data fault to check that the interrupt wins. It also asserts extIrq and memAddrFault over flushed bubbles and while interrupts are masked; no trap should follow from either. Returns are placed between traps, so the redirect to the saved PC is compared against the handler redirect and the mode bits are seen to toggle. Directed runs then try overflow alone, data fault alone, and a two-cycle stall, which must delay the commit by exactly two cycles.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    CAUSE_IRQ      = 3'd0,
    CAUSE_FETCH    = 3'd1,
    CAUSE_ILLEGAL  = 3'd2,
    CAUSE_OVERFLOW = 3'd3,
    CAUSE_DATA     = 3'd4
  } cause_e;

  // strobes from commit control to the stage datapath
  typedef struct packed {
    logic   take;   // trap taken this cycle
    logic   ret;    // return from handler this cycle
    cause_e cause;  // cause of the trap being taken
  } ctrl_strobe_t;

endpackage

// File: rtl/trap_stage_path.sv
module trap_stage_path
  import trap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic            decIllegal,
  input  logic            exeOverflow,
  input  logic            stall,
  input  ctrl_strobe_t    strobe,
  output logic            commitValid,
  output logic            commitPend,
  output cause_e          commitCode,
  output logic [PC_W-1:0] commitPc,
  output cause_e          causeReg,
  output logic [PC_W-1:0] epcReg,
  output logic [PC_W-1:0] redirectPc
);

  localparam int NUM_SLOTS = 3;
  localparam int SLOT_D    = 0;
  localparam int SLOT_E    = 1;
  localparam int SLOT_M    = NUM_SLOTS - 1;

  // slot registers: decode, execute, memory
  logic            slotValid [NUM_SLOTS];
  logic            slotPend  [NUM_SLOTS];
  cause_e          slotCode  [NUM_SLOTS];
  logic [PC_W-1:0] slotPc    [NUM_SLOTS];

  // raise inputs of the stage feeding each slot: fetch, decode, execute
  logic            stageRaise [NUM_SLOTS];
  cause_e          stageCode  [NUM_SLOTS];

  logic            srcValid [NUM_SLOTS];
  logic            srcPend  [NUM_SLOTS];
  cause_e          srcCode  [NUM_SLOTS];
  logic [PC_W-1:0] srcPc    [NUM_SLOTS];

  logic            inValid [NUM_SLOTS];
  logic            inPend  [NUM_SLOTS];
  cause_e          inCode  [NUM_SLOTS];
  logic [PC_W-1:0] inPc    [NUM_SLOTS];

  logic flush;
  assign flush = strobe.take | strobe.ret;

  assign stageRaise[0] = fetchFault;
  assign stageRaise[1] = decIllegal;
  assign stageRaise[2] = exeOverflow;
  assign stageCode[0]  = CAUSE_FETCH;
  assign stageCode[1]  = CAUSE_ILLEGAL;
  assign stageCode[2]  = CAUSE_OVERFLOW;

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (i == SLOT_D) begin : g_from_fetch
        assign srcValid[i] = fetchValid;
        assign srcPend[i]  = 1'b0;
        assign srcCode[i]  = CAUSE_IRQ;
        assign srcPc[i]    = fetchPc;
      end else begin : g_from_prev
        assign srcValid[i] = slotValid[i-1];
        assign srcPend[i]  = slotPend[i-1];
        assign srcCode[i]  = slotCode[i-1];
        assign srcPc[i]    = slotPc[i-1];
      end
      // an earlier fault is kept; bubbles carry nothing
      assign inValid[i] = srcValid[i];
      assign inPend[i]  = srcValid[i] & (srcPend[i] | stageRaise[i]);
      assign inCode[i]  = srcPend[i] ? srcCode[i]
                        : (inPend[i] ? stageCode[i] : CAUSE_IRQ);
      assign inPc[i]    = srcValid[i] ? srcPc[i] : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotValid[i] <= 1'b0;
        slotPend[i]  <= 1'b0;
        slotCode[i]  <= CAUSE_IRQ;
        slotPc[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (flush || (stall && i == SLOT_E)) begin
          slotValid[i] <= 1'b0;
          slotPend[i]  <= 1'b0;
          slotCode[i]  <= CAUSE_IRQ;
          slotPc[i]    <= '0;
        end else if (!(stall && i == SLOT_D)) begin
          slotValid[i] <= inValid[i];
          slotPend[i]  <= inPend[i];
          slotCode[i]  <= inCode[i];
          slotPc[i]    <= inPc[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= CAUSE_IRQ;
      epcReg   <= '0;
    end else if (strobe.take) begin
      causeReg <= strobe.cause;
      epcReg   <= slotPc[SLOT_M];
    end
  end

  assign commitValid = slotValid[SLOT_M];
  assign commitPend  = slotPend[SLOT_M];
  assign commitCode  = slotCode[SLOT_M];
  assign commitPc    = slotPc[SLOT_M];
  assign redirectPc  = strobe.take ? HANDLER_PC : epcReg;

  // R5: the saved PC and cause follow the trapped instruction
  p_epc_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (epcReg == $past(slotPc[SLOT_M])) && (causeReg == $past(strobe.cause)));

  // R9: a flush leaves bubbles behind
  p_flush_bubbles_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !slotValid[SLOT_D] && !slotValid[SLOT_E] && !slotValid[SLOT_M] && !slotPend[SLOT_M]);

  // R10: decode is frozen by a stall and execute receives a bubble
  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !flush) |=> (slotPc[SLOT_D] == $past(slotPc[SLOT_D]))
                        && (slotPend[SLOT_D] == $past(slotPend[SLOT_D]))
                        && !slotValid[SLOT_E]);

endmodule

// File: rtl/trap_commit_ctrl.sv
module trap_commit_ctrl
  import trap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         commitValid,
  input  logic         commitPend,
  input  cause_e       commitCode,
  input  logic         memAddrFault,
  input  logic         extIrq,
  input  logic         retExc,
  output ctrl_strobe_t strobe,
  output logic         irqEnable,
  output logic         kernelMode,
  output logic         killFetch,
  output logic         killDecode,
  output logic         killExecute,
  output logic         suppressWb,
  output logic         redirectValid
);

  logic irqHit;
  logic syncHit;
  logic takeNow;
  logic retNow;

  assign irqHit  = commitValid & irqEnable & extIrq;
  assign syncHit = commitValid & (commitPend | memAddrFault);
  assign takeNow = irqHit | syncHit;
  assign retNow  = commitValid & retExc & ~takeNow;

  always_comb begin
    strobe.take  = takeNow;
    strobe.ret   = retNow;
    if (irqHit)          strobe.cause = CAUSE_IRQ;
    else if (commitPend) strobe.cause = commitCode;
    else                 strobe.cause = CAUSE_DATA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnable  <= 1'b0;
      kernelMode <= 1'b1;
    end else if (takeNow) begin
      irqEnable  <= 1'b0;
      kernelMode <= 1'b1;
    end else if (retNow) begin
      irqEnable  <= 1'b1;
      kernelMode <= 1'b0;
    end
  end

  assign killFetch     = takeNow | retNow;
  assign killDecode    = takeNow | retNow;
  assign killExecute   = takeNow | retNow;
  assign suppressWb    = takeNow;
  assign redirectValid = takeNow | retNow;

  // R6: a trap masks interrupts and enters kernel mode
  p_trap_masks_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !irqEnable && kernelMode);

  // R7: a return unmasks interrupts and leaves kernel mode
  p_return_unmasks_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ret |=> irqEnable && !kernelMode);

  // R8: an interrupt cannot be taken twice in a row
  p_no_back_to_back_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.cause == CAUSE_IRQ) |=> !(strobe.take && strobe.cause == CAUSE_IRQ));

  // R7: trap and return never coincide
  p_take_ret_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.take && strobe.ret));

endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
  import trap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic            decIllegal,
  input  logic            exeOverflow,
  input  logic            memAddrFault,
  input  logic            extIrq,
  input  logic            retExc,
  input  logic            stall,
  output logic            killFetch,
  output logic            killDecode,
  output logic            killExecute,
  output logic            suppressWb,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic [2:0]      causeReg,
  output logic [PC_W-1:0] epcReg,
  output logic            irqEnable,
  output logic            kernelMode
);

  ctrl_strobe_t    strobe;
  logic            commitValid;
  logic            commitPend;
  cause_e          commitCode;
  logic [PC_W-1:0] commitPc;
  cause_e          causeVal;

  trap_stage_path #(
    .PC_W       (PC_W),
    .HANDLER_PC (HANDLER_PC)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .fetchValid  (fetchValid),
    .fetchPc     (fetchPc),
    .fetchFault  (fetchFault),
    .decIllegal  (decIllegal),
    .exeOverflow (exeOverflow),
    .stall       (stall),
    .strobe      (strobe),
    .commitValid (commitValid),
    .commitPend  (commitPend),
    .commitCode  (commitCode),
    .commitPc    (commitPc),
    .causeReg    (causeVal),
    .epcReg      (epcReg),
    .redirectPc  (redirectPc)
  );

  trap_commit_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .commitValid   (commitValid),
    .commitPend    (commitPend),
    .commitCode    (commitCode),
    .memAddrFault  (memAddrFault),
    .extIrq        (extIrq),
    .retExc        (retExc),
    .strobe        (strobe),
    .irqEnable     (irqEnable),
    .kernelMode    (kernelMode),
    .killFetch     (killFetch),
    .killDecode    (killDecode),
    .killExecute   (killExecute),
    .suppressWb    (suppressWb),
    .redirectValid (redirectValid)
  );

  assign causeReg = causeVal;

  // R2: the PC of a committing valid slot is what a trap records
  p_commit_pc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && commitValid) |=> epcReg == $past(commitPc));

endmodule

// File: tb/trap_commit_unit_bench.sv
module trap_commit_unit_bench;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rstN;
  logic            fetchValid, fetchFault, decIllegal, exeOverflow;
  logic            memAddrFault, extIrq, retExc, stall;
  logic [PC_W-1:0] fetchPc;
  logic            killFetch, killDecode, killExecute, suppressWb, redirectValid;
  logic [PC_W-1:0] redirectPc, epcReg;
  logic [2:0]      causeReg;
  logic            irqEnable, kernelMode;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trap_commit_unit u_trap_commit_unit (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchFault(fetchFault), .decIllegal(decIllegal), .exeOverflow(exeOverflow),
    .memAddrFault(memAddrFault), .extIrq(extIrq), .retExc(retExc), .stall(stall),
    .killFetch(killFetch), .killDecode(killDecode), .killExecute(killExecute),
    .suppressWb(suppressWb), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .causeReg(causeReg), .epcReg(epcReg), .irqEnable(irqEnable), .kernelMode(kernelMode)
  );

  typedef struct packed {
    logic       fv;  logic [7:0] pc;
    logic       ff;  logic di; logic eo; logic ma; logic irq; logic ret; logic stl;
    logic       eSup; logic eKill; logic eRed; logic [7:0] eRpc;
    logic [2:0] eCause; logic [7:0] eEpc; logic eIen; logic eKern;
  } vec_t;

  localparam logic N = 1'b0;
  localparam logic Y = 1'b1;
  localparam int NUM_VEC = 25;

  // each row is one cycle: inputs, then outputs expected before the edge
  localparam vec_t VEC [NUM_VEC] = '{
    '{Y,8'h10,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,N,Y}, // R1 state holds
    '{Y,8'h14,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,N,Y},
    '{Y,8'h18,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,N,Y},
    '{Y,8'h1C,N,N,N,N,N,Y,N, N,Y,Y,8'h00, 3'd0,8'h00,N,Y}, // R7 return
    '{Y,8'h20,Y,N,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,Y,N}, // R2 fetch fault rides
    '{Y,8'h24,N,Y,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,Y,N},
    '{Y,8'h28,N,N,Y,N,N,N,N, N,N,N,8'h00, 3'd0,8'h00,Y,N},
    '{Y,8'h2C,N,N,N,Y,N,N,N, Y,Y,Y,8'h80, 3'd0,8'h00,Y,N}, // R3 cause 1 wins
    '{Y,8'h30,N,N,N,Y,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,N,Y}, // R9 bubble, R8 masked
    '{Y,8'h34,N,N,N,N,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,N,Y},
    '{Y,8'h38,N,N,N,N,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,N,Y},
    '{Y,8'h3C,N,N,N,N,Y,Y,N, N,Y,Y,8'h20, 3'd1,8'h20,N,Y}, // R8 masked irq, R7
    '{Y,8'h40,N,N,N,N,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,Y,N}, // R8 bubble
    '{Y,8'h44,N,Y,N,N,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,Y,N},
    '{Y,8'h48,N,N,Y,N,Y,N,N, N,N,N,8'h00, 3'd1,8'h20,Y,N},
    '{Y,8'h4C,N,N,N,Y,N,N,N, Y,Y,Y,8'h80, 3'd1,8'h20,Y,N}, // R3 cause 2 wins
    '{Y,8'h50,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,N,Y},
    '{Y,8'h54,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,N,Y},
    '{Y,8'h58,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,N,Y},
    '{Y,8'h5C,N,N,N,N,N,Y,N, N,Y,Y,8'h40, 3'd2,8'h40,N,Y}, // R7 back to saved PC
    '{Y,8'h60,Y,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,Y,N},
    '{Y,8'h64,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,Y,N},
    '{Y,8'h68,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd2,8'h40,Y,N},
    '{Y,8'h6C,N,N,N,Y,Y,N,N, Y,Y,Y,8'h80, 3'd2,8'h40,Y,N}, // R4 irq beats faults
    '{N,8'h00,N,N,N,N,N,N,N, N,N,N,8'h00, 3'd0,8'h60,N,Y}  // R4 R6 cause 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply one cycle of inputs after the falling edge, settle before sampling
  task automatic cyc(input logic fv, input logic [7:0] pc, input logic ff, input logic di,
                     input logic eo, input logic ma, input logic irq, input logic ret,
                     input logic stl);
    @(negedge clk);
    fetchValid = fv; fetchPc = {24'h0, pc}; fetchFault = ff; decIllegal = di;
    exeOverflow = eo; memAddrFault = ma; extIrq = irq; retExc = ret; stall = stl;
    #5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    fetchValid = 0; fetchPc = '0; fetchFault = 0; decIllegal = 0; exeOverflow = 0;
    memAddrFault = 0; extIrq = 0; retExc = 0; stall = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #5;
    // R1 reset state
    check("R1 killFetch", 32'(killFetch), 0);
    check("R1 suppressWb", 32'(suppressWb), 0);
    check("R1 redirectValid", 32'(redirectValid), 0);
    check("R1 causeReg", 32'(causeReg), 0);
    check("R1 epcReg", epcReg, 0);
    check("R1 irqEnable", 32'(irqEnable), 0);
    check("R1 kernelMode", 32'(kernelMode), 1);

    for (int k = 0; k < NUM_VEC; k++) begin
      cyc(VEC[k].fv, VEC[k].pc, VEC[k].ff, VEC[k].di, VEC[k].eo, VEC[k].ma,
          VEC[k].irq, VEC[k].ret, VEC[k].stl);
      check("R5 R8 R9 suppressWb", 32'(suppressWb), 32'(VEC[k].eSup));
      check("R5 R7 killFetch", 32'(killFetch), 32'(VEC[k].eKill));
      check("R5 R7 killExecute", 32'(killExecute), 32'(VEC[k].eKill));
      check("R5 R7 redirectValid", 32'(redirectValid), 32'(VEC[k].eRed));
      if (VEC[k].eRed)
        check("R5 R7 redirectPc", redirectPc, 32'(VEC[k].eRpc));
      check("R2 R3 R4 causeReg", 32'(causeReg), 32'(VEC[k].eCause));
      check("R2 R5 epcReg", epcReg, 32'(VEC[k].eEpc));
      check("R6 R7 irqEnable", 32'(irqEnable), 32'(VEC[k].eIen));
      check("R6 R7 kernelMode", 32'(kernelMode), 32'(VEC[k].eKern));
    end

    // R3 overflow alone gives cause 3
    cyc(1, 8'h70, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 1, 0, 0, 0, 0);
    check("R2 overflow not early", 32'(suppressWb), 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R5 overflow trap", 32'(suppressWb), 1);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R3 overflow cause", 32'(causeReg), 3);
    check("R5 overflow epc", epcReg, 32'h70);

    // R3 data address fault alone gives cause 4
    cyc(1, 8'h90, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    check("R5 data trap", 32'(suppressWb), 1);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R3 data cause", 32'(causeReg), 4);
    check("R5 data epc", epcReg, 32'h90);

    // R10 two stall cycles delay commit by two
    cyc(1, 8'hA0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 8'hA4, 0, 0, 0, 0, 0, 0, 1);
    check("R10 stall cycle 1", 32'(suppressWb), 0);
    cyc(1, 8'hA4, 0, 0, 0, 0, 0, 0, 1);
    check("R10 stall cycle 2", 32'(suppressWb), 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R10 after stall 1", 32'(suppressWb), 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R10 after stall 2", 32'(suppressWb), 0);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R10 delayed trap", 32'(suppressWb), 1);
    cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    check("R10 held fault cause", 32'(causeReg), 1);
    check("R10 held pc", epcReg, 32'hA0);

    finish_run();
  end

endmodule